// File: doc/BRIEF.md
# Double-Data-Rate Serial Output Selector

This block turns a stream of bit pairs into a serial line that carries two bits in every clock period. One pair is offered per rising edge on `pair_first`/`pair_second` with `pair_valid`. A launch stage registers the pair on the rising edge. Two capture registers then hold the first and the second bit. A 2:1 selector whose select is the clock itself picks between them, so each bit is held on the line for half a clock period.

Three compile-time switches choose the clock edge of each capture register and the polarity of the select. Of the eight combinations, only four put the first bit of a pair on the line before the second bit. The other four cannot be built. The default takes the first bit on the falling edge, the second bit on the rising edge, and uses the inverted clock as the select. With this setting, data that arrives late still has half a cycle of slack before it slips into the next clock cycle. `LANES` copies the whole path for several parallel lines.

Top module: `ddr_serial_out`

## Requirements
- R1: Parameters `FIRST_ON_NEG`, `SECOND_ON_NEG` and `SEL_INVERT` (1 = falling edge / inverted select) choose the configuration. The defaults are 1, 0, 1: first bit on the falling edge, second on the rising edge, inverted select.
- R2: Only four (first edge, second edge, select) combinations are accepted: (rise, rise, inverted), (fall, rise, true), (fall, rise, inverted) and (fall, fall, true). Any other combination stops elaboration. The package function `ddr_cfg_legal` returns 1 for exactly these four.
- R3: A pair is taken into the launch stage on a rising edge where `pair_valid` is 1.
- R4: A rising edge with `pair_valid` at 0 produces an idle slot: the line is 0 for both halves of that slot, whatever the data inputs are.
- R5: Each pair is sent first bit, then second bit, in two consecutive half periods. Halves are numbered from the rising edge that launches the pair. The first bit fills the next half (the low phase) for (fall, rise, true) and (fall, fall, true). It fills the half after that (the next high phase) for (rise, rise, inverted) and (fall, rise, inverted).
- R6: With the true select the line shows the second-bit register while the clock is high and the first-bit register while it is low. With the inverted select the two phases are swapped.
- R7: Reset is synchronous and active low, and it clears every register on its own edge. During reset, and after it until the first valid pair comes out, the line is 0.
- R8: A pair of two 1 bits keeps the line at 1 for the whole period. Nothing in the select path lets the two select terms drift apart.
- R9: Bit order and timing stay correct across idle-to-valid and valid-to-idle changes, and for back-to-back pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the select of the output selector |
| rst_n | input | 1 | Synchronous active-low reset |
| pair_valid | input | 1 | A pair is offered on this rising edge |
| pair_first | input | LANES | Bit sent first, one per lane |
| pair_second | input | LANES | Bit sent second, one per lane |
| ser_out | output | LANES | Double-data-rate serial line, one per lane |

## Verification
The bench builds four copies side by side, one for each legal configuration: the default (fall, rise, inverted), plus (rise, rise, inverted), (fall, fall, true) and (fall, rise, true). All four get the same stream of pairs. This covers both select polarities, both one-half and one-period latencies, and both same-edge and split-edge capture against one reference model. The line is sampled in the middle of every half period. The bench also works out, for all eight combinations, whether the first bit can lead, and compares that with the acceptance rule the top enforces. The illegal combinations are covered by the elaboration stop itself.

// File: rtl/ddr_mux_pkg.sv
// Package: configuration rule shared by the serial output selector.
// Assumes: the capture registers are loaded from a rising-edge launch stage.
package ddr_mux_pkg;

    // True when the configuration puts the first bit on the line before the second.
    function automatic bit ddr_cfg_legal(input bit first_neg, input bit second_neg,
                                         input bit sel_inv);
        return (first_neg && !second_neg)
            || (!first_neg && !second_neg && sel_inv)
            || (first_neg && second_neg && !sel_inv);
    endfunction

endpackage

// File: rtl/ddr_launch_stage.sv
// Module: ddr_launch_stage
// Registers an offered bit pair on the rising edge. An idle slot loads zeros.
// Assumes: rst_n is synchronous to clk.
module ddr_launch_stage #(
    parameter int LANES = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pair_valid,
    input  logic [LANES-1:0] pair_first,
    input  logic [LANES-1:0] pair_second,
    output logic [LANES-1:0] launch_first,
    output logic [LANES-1:0] launch_second
);

    // Take the pair when it is valid; otherwise load the idle value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            launch_first  <= '0;
            launch_second <= '0;
        end else if (pair_valid) begin
            launch_first  <= pair_first;
            launch_second <= pair_second;
        end else begin
            launch_first  <= '0;
            launch_second <= '0;
        end
    end

    a_r4_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_valid |=> (launch_first == '0 && launch_second == '0));

    a_r3_valid_taken: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |=> (launch_first == $past(pair_first)
                        && launch_second == $past(pair_second)));

    a_r7_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (launch_first == '0 && launch_second == '0));

endmodule

// File: rtl/ddr_capture_reg.sv
// Module: ddr_capture_reg
// Capture register. NEG_EDGE picks the clock edge it loads on.
// Assumes: the synchronous reset is sampled on the same edge the register uses.
module ddr_capture_reg #(
    parameter int LANES    = 1,
    parameter bit NEG_EDGE = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] d,
    output logic [LANES-1:0] q
);

    if (NEG_EDGE) begin : g_fall
        // Load on the falling edge.
        always_ff @(negedge clk) begin
            if (!rst_n) q <= '0;
            else        q <= d;
        end
    end else begin : g_rise
        // Load on the rising edge.
        always_ff @(posedge clk) begin
            if (!rst_n) q <= '0;
            else        q <= d;
        end
    end

endmodule

// File: rtl/ddr_phase_mux.sv
// Module: ddr_phase_mux
// 2:1 selector with the clock as select. A single select term drives every lane.
// Assumes: in0 holds the first bit and in1 holds the second bit.
module ddr_phase_mux #(
    parameter int LANES   = 1,
    parameter bit SEL_INV = 1'b1
) (
    input  logic             clk,
    input  logic [LANES-1:0] in0,
    input  logic [LANES-1:0] in1,
    output logic [LANES-1:0] y
);

    logic sel;

    // One select term derived from the clock; no separate complement path.
    always_comb sel = clk ^ SEL_INV;

    // Choose input 1 while the select is high, input 0 otherwise.
    always_comb y = sel ? in1 : in0;

endmodule

// File: rtl/ddr_serial_out.sv
// Module: ddr_serial_out (top)
// Sends bit pairs on a double-data-rate line: a launch stage, two capture
// registers on selectable edges, and a clock-selected 2:1 selector.
// Assumes: rst_n is synchronous; only configurations that keep first-then-second order are built.
module ddr_serial_out #(
    parameter int LANES         = 1,
    parameter bit FIRST_ON_NEG  = 1'b1,
    parameter bit SECOND_ON_NEG = 1'b0,
    parameter bit SEL_INVERT    = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pair_valid,
    input  logic [LANES-1:0] pair_first,
    input  logic [LANES-1:0] pair_second,
    output logic [LANES-1:0] ser_out
);

    localparam bit CfgOk = ddr_mux_pkg::ddr_cfg_legal(FIRST_ON_NEG, SECOND_ON_NEG, SEL_INVERT);

    // R2: stop elaboration for a configuration that would swap the bit order.
    if (!CfgOk) begin : g_bad_cfg
        $error("ddr_serial_out: edge/select combination sends second bit first");
    end

    logic [LANES-1:0] launch_first;
    logic [LANES-1:0] launch_second;
    logic [LANES-1:0] cap_first;
    logic [LANES-1:0] cap_second;

    ddr_launch_stage #(.LANES(LANES)) u_launch (
        .clk          (clk),
        .rst_n        (rst_n),
        .pair_valid   (pair_valid),
        .pair_first   (pair_first),
        .pair_second  (pair_second),
        .launch_first (launch_first),
        .launch_second(launch_second)
    );

    ddr_capture_reg #(.LANES(LANES), .NEG_EDGE(FIRST_ON_NEG)) u_cap_first (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (launch_first),
        .q    (cap_first)
    );

    ddr_capture_reg #(.LANES(LANES), .NEG_EDGE(SECOND_ON_NEG)) u_cap_second (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (launch_second),
        .q    (cap_second)
    );

    ddr_phase_mux #(.LANES(LANES), .SEL_INV(SEL_INVERT)) u_mux (
        .clk(clk),
        .in0(cap_first),
        .in1(cap_second),
        .y  (ser_out)
    );

    // R6: value on the line just before the falling edge, i.e. in the high phase.
    a_r6_high_phase_src: assert property (@(negedge clk) disable iff (!rst_n)
        ser_out == (SEL_INVERT ? cap_first : cap_second));

    // R6: value on the line just before the rising edge, i.e. in the low phase.
    a_r6_low_phase_src: assert property (@(posedge clk) disable iff (!rst_n)
        ser_out == (SEL_INVERT ? cap_second : cap_first));

    // R8: when both registers hold 1 the line is 1 in the low phase.
    a_r8_ones_low: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_first & cap_second & ~ser_out) == '0);

    // R8: when both registers hold 1 the line is 1 in the high phase.
    a_r8_ones_high: assert property (@(negedge clk) disable iff (!rst_n)
        (cap_first & cap_second & ~ser_out) == '0);

endmodule

// File: tb/tb_ddr_serial_out.sv
`timescale 1ns/1ps
// Bench: four legal configurations get one stream of pairs; the line is sampled mid-half.
module tb_ddr_serial_out;

    localparam int NCYC = 400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pv_in = 1'b0;
    logic f_in = 1'b0;
    logic s_in = 1'b0;
    logic o_np_m, o_pp_m, o_nn_p, o_np_p;

    bit pv[0:NCYC+1];
    bit df[0:NCYC+1];
    bit ds[0:NCYC+1];

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    // R1: default parameters
    ddr_serial_out dut (.clk(clk), .rst_n(rst_n), .pair_valid(pv_in),
        .pair_first(f_in), .pair_second(s_in), .ser_out(o_np_m));
    ddr_serial_out #(.FIRST_ON_NEG(1'b0), .SECOND_ON_NEG(1'b0), .SEL_INVERT(1'b1)) dut_pp_m (
        .clk(clk), .rst_n(rst_n), .pair_valid(pv_in),
        .pair_first(f_in), .pair_second(s_in), .ser_out(o_pp_m));
    ddr_serial_out #(.FIRST_ON_NEG(1'b1), .SECOND_ON_NEG(1'b1), .SEL_INVERT(1'b0)) dut_nn_p (
        .clk(clk), .rst_n(rst_n), .pair_valid(pv_in),
        .pair_first(f_in), .pair_second(s_in), .ser_out(o_nn_p));
    ddr_serial_out #(.FIRST_ON_NEG(1'b1), .SECOND_ON_NEG(1'b0), .SEL_INVERT(1'b0)) dut_np_p (
        .clk(clk), .rst_n(rst_n), .pair_valid(pv_in),
        .pair_first(f_in), .pair_second(s_in), .ser_out(o_np_p));

    // Half (counted from the launching rising edge) in which a register's bit is first shown.
    function automatic int shown_half(bit neg, bit show_high);
        int c = neg ? 1 : 2;
        int par = show_high ? 0 : 1;
        return ((c % 2) == par) ? c : c + 1;
    endfunction

    // First-bit half for a configuration: inverted select shows first bit in high phase.
    function automatic int first_half(bit fn, bit inv);
        return shown_half(fn, inv);
    endfunction

    // Order rule: second bit must follow in the very next half.
    function automatic bit bench_legal(bit fn, bit sn, bit inv);
        return shown_half(sn, !inv) == shown_half(fn, inv) + 1;
    endfunction

    function automatic logic exp_bit(int h, int d0);
        int r = h - d0;
        int k;
        if (r < 0) return 1'b0;
        k = r / 2;
        if (!pv[k]) return 1'b0;
        return (r % 2 == 0) ? df[k] : ds[k];
    endfunction

    function automatic string tag_of(int h, int d0, bit inv);
        int r = h - d0;
        int k;
        if (r < 0) return "R4";
        k = r / 2;
        if (!pv[k]) return "R4";
        if (df[k] && ds[k]) return "R8";
        if (k > 0 && !pv[k-1]) return "R9";
        if (!inv && (r % 2 == 1)) return "R6/R5";
        return "R3/R5";
    endfunction

    task automatic chk(input string tag, input string who, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0b expected %0b", tag, who, act, exp);
        end
    endtask

    task automatic check_half(int h);
        int d;
        d = first_half(1'b1, 1'b1);
        chk({"R1 ", tag_of(h, d, 1'b1)}, "np-", o_np_m, exp_bit(h, d));
        d = first_half(1'b0, 1'b1);
        chk(tag_of(h, d, 1'b1), "pp-", o_pp_m, exp_bit(h, d));
        d = first_half(1'b1, 1'b0);
        chk(tag_of(h, d, 1'b0), "nn+", o_nn_p, exp_bit(h, d));
        d = first_half(1'b1, 1'b0);
        chk(tag_of(h, d, 1'b0), "np+", o_np_p, exp_bit(h, d));
    endtask

    initial begin
        int r;
        void'($urandom(32'd1709));
        // R2: acceptance rule of the top against the bench's own ordering model
        for (int c = 0; c < 8; c++) begin
            chk("R2", "cfg rule", ddr_mux_pkg::ddr_cfg_legal(c[2], c[1], c[0]),
                bench_legal(c[2], c[1], c[0]));
        end
        for (int k = 0; k <= NCYC + 1; k++) begin
            r = $urandom;
            df[k] = r[0];
            ds[k] = r[1];
            pv[k] = (k > 5) && (r[3:2] != 2'b00);
        end
        // Directed slots: single bits, ones pairs, idle/valid flips
        for (int k = 6; k < 18; k++) begin
            case (k)
                6:  begin pv[k] = 1; df[k] = 1; ds[k] = 0; end
                7:  begin pv[k] = 1; df[k] = 0; ds[k] = 1; end
                8:  begin pv[k] = 1; df[k] = 1; ds[k] = 1; end
                9:  begin pv[k] = 1; df[k] = 1; ds[k] = 1; end
                10: begin pv[k] = 0; df[k] = 1; ds[k] = 1; end
                11: begin pv[k] = 1; df[k] = 1; ds[k] = 0; end
                12: begin pv[k] = 0; df[k] = 1; ds[k] = 1; end
                13: begin pv[k] = 1; df[k] = 0; ds[k] = 1; end
                14: begin pv[k] = 1; df[k] = 0; ds[k] = 0; end
                15: begin pv[k] = 0; df[k] = 1; ds[k] = 0; end
                16: begin pv[k] = 1; df[k] = 1; ds[k] = 1; end
                default: begin pv[k] = 1; df[k] = 1; ds[k] = 0; end
            endcase
        end
        pv_in = pv[0]; f_in = df[0]; s_in = ds[0];
        for (int j = 0; j < NCYC; j++) begin
            @(posedge clk);
            #2;
            if (j == 4) rst_n = 1'b1;
            pv_in = pv[j+1]; f_in = df[j+1]; s_in = ds[j+1];
            #3;
            if (j == 2 || j == 3) begin
                chk("R7", "np-", o_np_m, 1'b0);
                chk("R7", "pp-", o_pp_m, 1'b0);
                chk("R7", "nn+", o_nn_p, 1'b0);
                chk("R7", "np+", o_np_p, 1'b0);
            end
            if (j >= 6) check_half(2 * j);
            #10;
            if (j >= 6) check_half(2 * j + 1);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20 * (NCYC + 100));
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule